// File: doc/BRIEF.md
# Triple Observe-Only Capture Chain

This block gives a fault-checking controller a view of the signals in a triple-redundant design without sitting in their paths. Each redundant area has its own chain of observe-only cells. A cell only reads its signal and never drives it, so the observed path gains no delay. All three chains are controlled by the same two commands, sample and shift, and each chain has its own serial output. The controller compares the three serial outputs bit by bit. Because a chain belongs to exactly one area, a mismatch points straight to that area, and shifting the three chains side by side cuts the read-out time by three.

Each chain carries the controller's own observed outputs first. These are followed by one group of three cells for every functional output: the module result, its majority voter and its minority voter. Every clock the shared control decoder picks one operation. CAPTURE is chosen when sample is high, whatever shift is. SHIFT is chosen when only shift is high. HOLD is chosen when neither is high. The chosen operation is applied to every cell on the system clock edge. CAPTURE loads all cells in parallel. SHIFT moves each cell one place toward the serial output and pulls a zero in at the far end. HOLD keeps the contents. Any operation can follow any other on the next clock, and a new capture needs no clearing first.

Top module: `tri_obs_chain`

## Requirements
- R1: An active-low reset clears every cell of every chain, so all serial outputs read 0 after reset.
- R2: With sample high at a clock edge, every cell of every chain loads its observed input on that edge. The first bit (controller signal 0 of that area) appears on the serial output right after that edge.
- R3: With only shift high at a clock edge, each chain moves one position toward its output. Bits leave in this order: controller signals 0..N_CTRL-1, then for each output j in ascending order the module bit, the majority bit and the minority bit.
- R4: With neither command high, the serial outputs and the chain contents stay unchanged.
- R5: When sample and shift are both high, capture wins: the chain loads its observed inputs and does not shift.
- R6: Each shift pulls a 0 in at the far end. After N_CTRL+3*N_OUT shifts with no capture, the serial output is 0. A following capture reloads the chain with no clearing step.
- R7: Chain a observes only area a's slices: bits [a*N_CTRL +: N_CTRL] of the controller bus and bits [a*N_OUT +: N_OUT] of the module, majority and minority buses. Its output is serial output bit a.
- R8: Observed inputs that change while no capture happens have no effect on the chain contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all capture and shift happens on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_i | input | 1 | Capture command from the controller |
| shift_i | input | 1 | Shift command from the controller |
| ctrl_obs_i | input | N_AREA*N_CTRL | Controller outputs observed, area-major |
| mod_obs_i | input | N_AREA*N_OUT | Module outputs observed, area-major |
| maj_obs_i | input | N_AREA*N_OUT | Majority voter outputs observed, area-major |
| min_obs_i | input | N_AREA*N_OUT | Minority voter outputs observed, area-major |
| sdo_o | output | N_AREA | Serial output of each area's chain |

## Verification
A corrupted cell, a swapped load position or a wrong command priority shows up as a wrong bit on one area's serial output. It appears exactly as many shifts after the capture as the cell's distance from the output, at most N_CTRL+3*N_OUT clocks later. A bad shift or hold path shows on the very next clock. The bench compares every area's serial output with a chain model on every cycle, so a fault is reported on the first cycle where it reaches a port.

// File: rtl/tri_obs_chain_pkg.sv
package tri_obs_chain_pkg;

    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_SHIFT   = 2'd1,
        OP_CAPTURE = 2'd2
    } chain_op_e;

    function automatic int unsigned chain_len(input int unsigned n_ctrl, input int unsigned n_out);
        return n_ctrl + 3 * n_out;
    endfunction

endpackage

// File: rtl/chain_op_decode.sv
module chain_op_decode
    import tri_obs_chain_pkg::*;
(
    input  logic      sample_i,
    input  logic      shift_i,
    output chain_op_e op_o
);

    always_comb begin
        unique case ({sample_i, shift_i})
            2'b00:        op_o = OP_HOLD;
            2'b01:        op_o = OP_SHIFT;
            2'b10, 2'b11: op_o = OP_CAPTURE;
            default:      op_o = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/area_obs_chain.sv
module area_obs_chain
    import tri_obs_chain_pkg::*;
#(
    parameter int unsigned N_CTRL = 4,
    parameter int unsigned N_OUT  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  chain_op_e         op_i,
    input  logic [N_CTRL-1:0] ctrl_obs_i,
    input  logic [N_OUT-1:0]  mod_obs_i,
    input  logic [N_OUT-1:0]  maj_obs_i,
    input  logic [N_OUT-1:0]  min_obs_i,
    output logic              sdo_o
);

    localparam int unsigned LEN   = chain_len(N_CTRL, N_OUT);
    localparam int unsigned CNT_W = $clog2(LEN + 1);

    logic [LEN-1:0] cells;
    logic [LEN-1:0] load_vec;

    // position 0 is nearest the serial output
    for (genvar c = 0; c < N_CTRL; c++) begin : g_ctrl
        assign load_vec[c] = ctrl_obs_i[c];
    end
    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        assign load_vec[N_CTRL + 3*j]     = mod_obs_i[j];
        assign load_vec[N_CTRL + 3*j + 1] = maj_obs_i[j];
        assign load_vec[N_CTRL + 3*j + 2] = min_obs_i[j];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cells <= '0;
        end else begin
            unique case (op_i)
                OP_HOLD:    cells <= cells;
                OP_SHIFT:   cells <= {1'b0, cells[LEN-1:1]};
                OP_CAPTURE: cells <= load_vec;
                default:    cells <= cells;
            endcase
        end
    end

    assign sdo_o = cells[0];

    // checker: shifts since last capture, saturating at chain length
    logic [CNT_W-1:0] drain_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drain_cnt <= CNT_W'(LEN);
        end else if (op_i == OP_CAPTURE) begin
            drain_cnt <= '0;
        end else if (op_i == OP_SHIFT && drain_cnt != CNT_W'(LEN)) begin
            drain_cnt <= drain_cnt + 1'b1;
        end
    end

    p_capture_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CAPTURE) |=> (sdo_o == $past(ctrl_obs_i[0])));

    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_HOLD) |=> $stable(sdo_o));

    p_drained_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_cnt == CNT_W'(LEN)) |-> (sdo_o == 1'b0));

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sdo_o == 1'b0));

endmodule

// File: rtl/tri_obs_chain.sv
module tri_obs_chain
    import tri_obs_chain_pkg::*;
#(
    parameter int unsigned N_AREA = 3,
    parameter int unsigned N_CTRL = 4,
    parameter int unsigned N_OUT  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_i,
    input  logic                     shift_i,
    input  logic [N_AREA*N_CTRL-1:0] ctrl_obs_i,
    input  logic [N_AREA*N_OUT-1:0]  mod_obs_i,
    input  logic [N_AREA*N_OUT-1:0]  maj_obs_i,
    input  logic [N_AREA*N_OUT-1:0]  min_obs_i,
    output logic [N_AREA-1:0]        sdo_o
);

    chain_op_e op;

    chain_op_decode u_dec (
        .sample_i (sample_i),
        .shift_i  (shift_i),
        .op_o     (op)
    );

    for (genvar a = 0; a < N_AREA; a++) begin : g_area
        area_obs_chain #(
            .N_CTRL (N_CTRL),
            .N_OUT  (N_OUT)
        ) u_chain (
            .clk        (clk),
            .rst_n      (rst_n),
            .op_i       (op),
            .ctrl_obs_i (ctrl_obs_i[a*N_CTRL +: N_CTRL]),
            .mod_obs_i  (mod_obs_i[a*N_OUT +: N_OUT]),
            .maj_obs_i  (maj_obs_i[a*N_OUT +: N_OUT]),
            .min_obs_i  (min_obs_i[a*N_OUT +: N_OUT]),
            .sdo_o      (sdo_o[a])
        );

        p_capture_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (sample_i && shift_i) |=> (sdo_o[a] == $past(ctrl_obs_i[a*N_CTRL])));
    end

endmodule

// File: tb/tri_obs_chain_bench.sv
module tri_obs_chain_bench;

    localparam int N_AREA = 3;
    localparam int N_CTRL = 4;
    localparam int N_OUT  = 8;
    localparam int L      = N_CTRL + 3*N_OUT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_i = 1'b0;
    logic shift_i = 1'b0;
    logic [N_AREA*N_CTRL-1:0] ctrl_obs_i = '0;
    logic [N_AREA*N_OUT-1:0]  mod_obs_i = '0;
    logic [N_AREA*N_OUT-1:0]  maj_obs_i = '0;
    logic [N_AREA*N_OUT-1:0]  min_obs_i = '0;
    logic [N_AREA-1:0]        sdo_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic exp_m [N_AREA][L];

    always #2.5 clk = ~clk;

    tri_obs_chain #(.N_AREA(N_AREA), .N_CTRL(N_CTRL), .N_OUT(N_OUT)) u_tri_obs_chain (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .shift_i(shift_i),
        .ctrl_obs_i(ctrl_obs_i), .mod_obs_i(mod_obs_i), .maj_obs_i(maj_obs_i),
        .min_obs_i(min_obs_i), .sdo_o(sdo_o));

    function automatic logic obs_bit(input int a, input int k);
        int r;
        if (k < N_CTRL) return ctrl_obs_i[a*N_CTRL + k];
        r = k - N_CTRL;
        case (r % 3)
            0:       return mod_obs_i[a*N_OUT + r/3];
            1:       return maj_obs_i[a*N_OUT + r/3];
            default: return min_obs_i[a*N_OUT + r/3];
        endcase
    endfunction

    task automatic check(input logic [N_AREA-1:0] act, input logic [N_AREA-1:0] exp, input string req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: sdo=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [N_AREA-1:0] model_head();
        logic [N_AREA-1:0] v;
        for (int a = 0; a < N_AREA; a++) v[a] = exp_m[a][0];
        return v;
    endfunction

    task automatic randomize_obs();
        ctrl_obs_i = N_AREA*N_CTRL'($urandom);
        mod_obs_i  = N_AREA*N_OUT'($urandom);
        maj_obs_i  = N_AREA*N_OUT'($urandom);
        min_obs_i  = N_AREA*N_OUT'($urandom);
    endtask

    // called just after a negedge; applies one clock and checks at the next negedge
    task automatic cyc(input logic c, input logic s, input string req);
        sample_i = c;
        shift_i  = s;
        @(posedge clk);
        #0.1;
        if (c) begin
            for (int a = 0; a < N_AREA; a++)
                for (int k = 0; k < L; k++) exp_m[a][k] = obs_bit(a, k);
        end else if (s) begin
            for (int a = 0; a < N_AREA; a++) begin
                for (int k = 0; k < L-1; k++) exp_m[a][k] = exp_m[a][k+1];
                exp_m[a][L-1] = 1'b0;
            end
        end
        @(negedge clk);
        check(sdo_o, model_head(), req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0A17));
        for (int a = 0; a < N_AREA; a++)
            for (int k = 0; k < L; k++) exp_m[a][k] = 1'b0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(sdo_o, 3'b000, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check(sdo_o, 3'b000, "R1");

        // R7: only area 1 controller bit 0 set
        ctrl_obs_i = '0;
        ctrl_obs_i[1*N_CTRL] = 1'b1;
        cyc(1'b1, 1'b0, "R2");
        check(sdo_o, 3'b010, "R7");

        // R2/R3: random pattern, full read-out in order
        randomize_obs();
        cyc(1'b1, 1'b0, "R2");
        for (int i = 0; i < L-1; i++) cyc(1'b0, 1'b1, "R3");

        // R3 directed order: area 0 majority bit of output 2 only
        ctrl_obs_i = '0; mod_obs_i = '0; maj_obs_i = '0; min_obs_i = '0;
        maj_obs_i[2] = 1'b1;
        cyc(1'b1, 1'b0, "R2");
        for (int i = 0; i < N_CTRL + 3*2 + 1; i++) cyc(1'b0, 1'b1, "R3");
        check(sdo_o, 3'b001, "R3");

        // R4/R8: hold while inputs change, then read out old contents
        randomize_obs();
        cyc(1'b1, 1'b0, "R2");
        cyc(1'b0, 1'b1, "R3");
        for (int i = 0; i < 6; i++) begin
            randomize_obs();
            cyc(1'b0, 1'b0, "R4");
        end
        for (int i = 0; i < 5; i++) begin
            randomize_obs();
            cyc(1'b0, 1'b1, "R8");
        end

        // R5: both commands at once
        randomize_obs();
        cyc(1'b1, 1'b1, "R5");
        cyc(1'b0, 1'b1, "R5");

        // R6: drain fully, then recapture with no clearing
        for (int i = 0; i < L; i++) cyc(1'b0, 1'b1, "R6");
        check(sdo_o, 3'b000, "R6");
        ctrl_obs_i = '1;
        cyc(1'b1, 1'b0, "R6");
        check(sdo_o, 3'b111, "R6");

        // random mix of commands and data
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            r = $urandom % 8;
            randomize_obs();
            cyc(r == 0 || r == 7, r >= 2, "R3");
        end

        finish_run();
    end

endmodule